// File: doc/BRIEF.md
# Out-of-Order Segment Reorder Tracker

This block keeps track of byte ranges of one connection's stream that were received ahead of the expected sequence number. It does not sort them. Instead it keeps two associative tables that share the same slot index. One table is searched by the first sequence number of each buffered range. The other is searched by the sequence number one past the last byte of each range. With these two keys, a new early segment finds in one step any buffered range it touches on either side. It then joins that range instead of taking a fresh slot.

When a segment arrives that sits exactly at the expected sequence number, the block checks whether a buffered range starts right where the new data ends. If one does, that range is released and the new expected sequence number moves past it. The upstream receive logic presents one segment per cycle: its sequence number, its payload length and a flag saying whether it is in order. One clock later it gets back a result code, a sequence number, a length, the occupancy count and a full flag. Storage of the payload bytes and window policy belong to other blocks.

Top module: `seg_reorder_tracker`

## Requirements
- R1: An in-order segment while no range is buffered touches neither table. It returns code 0 (pass), `res_seq` = seq+len and `res_len` = 0.
- R2: An out-of-order segment that touches no buffered range takes a free slot. It returns code 2 (stored), with `res_seq`/`res_len` equal to its own start and length, and `held` rises by one.
- R3: An out-of-order segment whose seq equals the end+1 of a buffered range extends that range. It returns code 3 with the combined start and length, and `held` stays unchanged.
- R4: An out-of-order segment whose seq+len equals the start of a buffered range prepends to it. It returns code 4 with start = seq and the combined length, and `held` stays unchanged.
- R5: An out-of-order segment touching ranges on both sides collapses all three into one entry. It returns code 5 with the outer start and the total length, and `held` falls by one.
- R6: An in-order segment whose seq+len equals the start of a buffered range removes that range. It returns code 1, with `res_seq` = that range's end+1, `res_len` = its length, and `held` falls by one.
- R7: An in-order segment that finds no following range returns code 0 with `res_seq` = seq+len and leaves the buffer unchanged.
- R8: `full` is 1 exactly when all DEPTH slots hold a range. An out-of-order segment that needs a new slot while full is dropped with code 6 and `held` unchanged. Joins into existing ranges still work while full.
- R9: All end+1 keys and expected-sequence results are computed modulo 2^SEQ_W, so ranges may straddle the wrap point.
- R10: A segment with zero length is ignored. It produces no `res_valid` and does not change the buffer.
- R11: An out-of-order segment makes exactly one lookup in each table and at most one entry write. An in-order segment makes at most one lookup, in the start-keyed table only.
- R12: The result appears with `res_valid` = 1 on the cycle after the segment is presented, and a new segment may be presented every cycle. After reset `held` = 0, `full` = 0 and `res_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_valid | input | 1 | A segment is presented this cycle |
| seg_seq | input | SEQ_W | First sequence number of the segment |
| seg_len | input | LEN_W | Payload length in bytes |
| seg_inorder | input | 1 | 1 when seg_seq equals the expected sequence number |
| res_valid | output | 1 | Result of the previous cycle's segment |
| res_code | output | 3 | 0 pass, 1 advanced, 2 stored, 3 joined previous, 4 joined next, 5 joined both, 6 dropped |
| res_seq | output | SEQ_W | Start of the resulting range, or the new expected sequence for in-order segments |
| res_len | output | LEN_W | Length of the resulting or released range |
| held | output | $clog2(DEPTH+1) | Number of buffered ranges |
| full | output | 1 | All slots occupied |

## Verification
A lost or stale slot in one of the two tables shows up at the latest when a neighbouring segment arrives. The join is then reported as a fresh store (code 2 instead of 3, 4 or 5), or an in-order segment passes with code 0 where it should have advanced. Both are visible on the cycle right after that segment. Occupancy errors show directly in `held` on the next cycle. Filling every slot and then draining them in order exposes any slot that was never freed, or freed twice, within DEPTH segments.

// File: rtl/seg_reorder_pkg.sv
package seg_reorder_pkg;

   typedef enum logic [2:0] {
      RC_PASS      = 3'd0,
      RC_ADVANCE   = 3'd1,
      RC_STORED    = 3'd2,
      RC_JOIN_PREV = 3'd3,
      RC_JOIN_NEXT = 3'd4,
      RC_JOIN_BOTH = 3'd5,
      RC_DROPPED   = 3'd6
   } rc_code_e;

endpackage

// File: rtl/seg_range_table.sv
module seg_range_table #(
   parameter int DEPTH = 32,
   parameter int KEY_W = 32,
   parameter int LEN_W = 22,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_en,
   input  logic [KEY_W-1:0] lk_key,
   output logic             hit,
   output logic [IDX_W-1:0] hit_idx,
   output logic [LEN_W-1:0] hit_len,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [KEY_W-1:0] wr_key,
   input  logic [LEN_W-1:0] wr_len,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] clr_idx,
   output logic [DEPTH-1:0] valid_o
);

   logic [KEY_W-1:0] key_q [DEPTH];
   logic [LEN_W-1:0] len_q [DEPTH];
   logic [DEPTH-1:0] vld_q;
   logic [DEPTH-1:0] match;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            key_q[i] <= '0;
            len_q[i] <= '0;
         end
      end else begin
         if (clr_en) vld_q[clr_idx] <= 1'b0;
         if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
            key_q[wr_idx] <= wr_key;
            len_q[wr_idx] <= wr_len;
         end
      end
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_match
      assign match[e] = lk_en && vld_q[e] && (key_q[e] == lk_key);
   end

   always_comb begin
      hit_idx = '0;
      hit_len = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (match[i]) begin
            hit_idx = hit_idx | IDX_W'(i);
            hit_len = hit_len | len_q[i];
         end
      end
   end

   assign hit     = |match;
   assign valid_o = vld_q;

   // R11
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

   // R5
   wr_clr_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && clr_en) |-> (wr_idx != clr_idx));

endmodule

// File: rtl/seg_slot_pick.sv
module seg_slot_pick #(
   parameter int DEPTH     = 32,
   parameter bit PICK_HIGH = 1'b0,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] busy,
   output logic             any_free,
   output logic [IDX_W-1:0] free_idx
);

   assign any_free = ~&busy;

   if (PICK_HIGH) begin : g_high
      always_comb begin
         free_idx = '0;
         for (int i = 0; i < DEPTH; i++)
            if (!busy[i]) free_idx = IDX_W'(i);
      end
   end else begin : g_low
      always_comb begin
         free_idx = '0;
         for (int i = DEPTH - 1; i >= 0; i--)
            if (!busy[i]) free_idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/seg_reorder_tracker.sv
module seg_reorder_tracker
   import seg_reorder_pkg::*;
#(
   parameter int DEPTH     = 32,
   parameter int SEQ_W     = 32,
   parameter int LEN_W     = 22,
   parameter bit PICK_HIGH = 1'b0,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seg_valid,
   input  logic [SEQ_W-1:0] seg_seq,
   input  logic [LEN_W-1:0] seg_len,
   input  logic             seg_inorder,
   output logic             res_valid,
   output logic [2:0]       res_code,
   output logic [SEQ_W-1:0] res_seq,
   output logic [LEN_W-1:0] res_len,
   output logic [CNT_W-1:0] held,
   output logic             full
);

   if (LEN_W > SEQ_W) begin : g_bad_len
      $error("seg_reorder_tracker: LEN_W must not exceed SEQ_W");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("seg_reorder_tracker: DEPTH must be at least 2");
   end

   logic             fire, ooo, ino;
   logic [SEQ_W-1:0] seg_end;
   logic             empty;

   logic             lk_s_en, lk_e_en;
   logic             nxt_hit, prv_hit;
   logic [IDX_W-1:0] nxt_idx, prv_idx;
   logic [LEN_W-1:0] nxt_len, prv_len;
   logic [DEPTH-1:0] s_valid, e_valid;

   logic             free_any;
   logic [IDX_W-1:0] free_idx;

   logic             wr_en, clr_en;
   logic [IDX_W-1:0] wr_idx, clr_idx;
   logic [SEQ_W-1:0] wr_start, wr_endp1;
   logic [LEN_W-1:0] wr_len;
   logic             inc, dec;
   rc_code_e         code_d;
   logic [SEQ_W-1:0] rseq_d;
   logic [LEN_W-1:0] rlen_d;

   logic [CNT_W-1:0] cnt_q;
   logic             rv_q;
   rc_code_e         code_q;
   logic [SEQ_W-1:0] rseq_q;
   logic [LEN_W-1:0] rlen_q;

   assign fire    = seg_valid && (seg_len != '0);
   assign ooo     = fire && !seg_inorder;
   assign ino     = fire && seg_inorder;
   assign seg_end = seg_seq + SEQ_W'(seg_len);
   assign empty   = (cnt_q == '0);

   // start-keyed table: searched with the segment's end+1
   assign lk_s_en = ooo || (ino && !empty);
   // end-keyed table: searched with the segment's start
   assign lk_e_en = ooo;

   seg_range_table #(.DEPTH(DEPTH), .KEY_W(SEQ_W), .LEN_W(LEN_W)) u_start_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_en   (lk_s_en),
      .lk_key  (seg_end),
      .hit     (nxt_hit),
      .hit_idx (nxt_idx),
      .hit_len (nxt_len),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_key  (wr_start),
      .wr_len  (wr_len),
      .clr_en  (clr_en),
      .clr_idx (clr_idx),
      .valid_o (s_valid)
   );

   seg_range_table #(.DEPTH(DEPTH), .KEY_W(SEQ_W), .LEN_W(LEN_W)) u_end_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_en   (lk_e_en),
      .lk_key  (seg_seq),
      .hit     (prv_hit),
      .hit_idx (prv_idx),
      .hit_len (prv_len),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_key  (wr_endp1),
      .wr_len  (wr_len),
      .clr_en  (clr_en),
      .clr_idx (clr_idx),
      .valid_o (e_valid)
   );

   seg_slot_pick #(.DEPTH(DEPTH), .PICK_HIGH(PICK_HIGH)) u_pick (
      .busy     (s_valid),
      .any_free (free_any),
      .free_idx (free_idx)
   );

   assign wr_endp1 = wr_start + SEQ_W'(wr_len);

   always_comb begin
      wr_en    = 1'b0;
      wr_idx   = free_idx;
      wr_start = seg_seq;
      wr_len   = seg_len;
      clr_en   = 1'b0;
      clr_idx  = nxt_idx;
      inc      = 1'b0;
      dec      = 1'b0;
      code_d   = RC_PASS;
      rseq_d   = seg_end;
      rlen_d   = '0;
      if (ooo) begin
         unique case ({prv_hit, nxt_hit})
            2'b00: begin
               if (free_any) begin
                  wr_en  = 1'b1;
                  inc    = 1'b1;
                  code_d = RC_STORED;
               end else begin
                  code_d = RC_DROPPED;
               end
            end
            2'b10: begin
               wr_en    = 1'b1;
               wr_idx   = prv_idx;
               wr_start = seg_seq - SEQ_W'(prv_len);
               wr_len   = prv_len + seg_len;
               code_d   = RC_JOIN_PREV;
            end
            2'b01: begin
               wr_en  = 1'b1;
               wr_idx = nxt_idx;
               wr_len = seg_len + nxt_len;
               code_d = RC_JOIN_NEXT;
            end
            default: begin
               wr_en    = 1'b1;
               wr_idx   = prv_idx;
               wr_start = seg_seq - SEQ_W'(prv_len);
               wr_len   = prv_len + seg_len + nxt_len;
               clr_en   = 1'b1;
               dec      = 1'b1;
               code_d   = RC_JOIN_BOTH;
            end
         endcase
         rseq_d = wr_start;
         rlen_d = wr_len;
      end else if (ino && nxt_hit) begin
         clr_en = 1'b1;
         dec    = 1'b1;
         code_d = RC_ADVANCE;
         rseq_d = seg_end + SEQ_W'(nxt_len);
         rlen_d = nxt_len;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         rv_q   <= 1'b0;
         code_q <= RC_PASS;
         rseq_q <= '0;
         rlen_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(inc) - CNT_W'(dec);
         rv_q  <= fire;
         if (fire) begin
            code_q <= code_d;
            rseq_q <= rseq_d;
            rlen_q <= rlen_d;
         end
      end
   end

   assign res_valid = rv_q;
   assign res_code  = code_q;
   assign res_seq   = rseq_q;
   assign res_len   = rlen_q;
   assign held      = cnt_q;
   assign full      = (cnt_q == CNT_W'(DEPTH));

   // R11
   ooo_two_lookups_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ooo |-> (lk_s_en && lk_e_en));

   // R11
   ino_no_end_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ino |-> !lk_e_en);

   // R1
   idle_no_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ino && held == '0) |-> (!lk_s_en && !lk_e_en && !wr_en && !clr_en));

   // R10
   zero_len_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && seg_len == '0) |=> (!res_valid && $stable(held)));

   // R8
   held_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      held <= CNT_W'(DEPTH));

   // R8
   drop_keeps_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code == 3'd6) |-> (held == $past(held)));

   // R6
   advance_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code == 3'd1) |-> (held == $past(held) - 1'b1));

   // R5
   both_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code == 3'd5) |-> (held == $past(held) - 1'b1));

   // R2
   store_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code == 3'd2) |-> (held == $past(held) + 1'b1));

   // R5
   tables_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid == e_valid) && ($countones(s_valid) == int'(held)));

endmodule

// File: tb/seg_reorder_tracker_tb_top.sv
module seg_reorder_tracker_tb_top;

   localparam int DEPTH = 32;
   localparam int SEQ_W = 32;
   localparam int LEN_W = 22;
   localparam int CNT_W = $clog2(DEPTH + 1);

   localparam logic [2:0] C_PASS = 3'd0, C_ADV = 3'd1, C_NEW = 3'd2,
                          C_JPREV = 3'd3, C_JNEXT = 3'd4, C_JBOTH = 3'd5,
                          C_DROP = 3'd6;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             seg_valid;
   logic [SEQ_W-1:0] seg_seq;
   logic [LEN_W-1:0] seg_len;
   logic             seg_inorder;
   logic             res_valid;
   logic [2:0]       res_code;
   logic [SEQ_W-1:0] res_seq;
   logic [LEN_W-1:0] res_len;
   logic [CNT_W-1:0] held;
   logic             full;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   seg_reorder_tracker #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .LEN_W(LEN_W)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .seg_valid   (seg_valid),
      .seg_seq     (seg_seq),
      .seg_len     (seg_len),
      .seg_inorder (seg_inorder),
      .res_valid   (res_valid),
      .res_code    (res_code),
      .res_seq     (res_seq),
      .res_len     (res_len),
      .held        (held),
      .full        (full)
   );

   task automatic check(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic drive(logic [SEQ_W-1:0] s, logic [LEN_W-1:0] l, logic io);
      seg_valid   = 1'b1;
      seg_seq     = s;
      seg_len     = l;
      seg_inorder = io;
   endtask

   task automatic send(logic [SEQ_W-1:0] s, logic [LEN_W-1:0] l, logic io);
      @(negedge clk);
      drive(s, l, io);
      @(negedge clk);
      seg_valid = 1'b0;
   endtask

   task automatic expect_res(string req, logic [2:0] c, logic [SEQ_W-1:0] s,
                             logic [LEN_W-1:0] l, int h);
      check(req, "res_valid", res_valid, 1);
      check(req, "res_code", res_code, c);
      check(req, "res_seq", res_seq, s);
      check(req, "res_len", res_len, l);
      check(req, "held", held, h);
   endtask

   task automatic t_inorder_idle();
      send(32'd0, 22'd100, 1'b1);
      expect_res("R1", C_PASS, 32'd100, 22'd0, 0);
   endtask

   task automatic t_joins();
      send(32'd200, 22'd50, 1'b0);
      expect_res("R2", C_NEW, 32'd200, 22'd50, 1);
      send(32'd150, 22'd50, 1'b0);
      expect_res("R4", C_JNEXT, 32'd150, 22'd100, 1);
      send(32'd250, 22'd20, 1'b0);
      expect_res("R3", C_JPREV, 32'd150, 22'd120, 1);
      send(32'd400, 22'd30, 1'b0);
      expect_res("R2", C_NEW, 32'd400, 22'd30, 2);
   endtask

   task automatic t_zero_len();
      send(32'd430, 22'd0, 1'b0);
      check("R10", "res_valid", res_valid, 0);
      check("R10", "held", held, 2);
   endtask

   task automatic t_bridge_and_advance();
      send(32'd270, 22'd130, 1'b0);
      expect_res("R5", C_JBOTH, 32'd150, 22'd280, 1);
      send(32'd0, 22'd10, 1'b1);
      expect_res("R7", C_PASS, 32'd10, 22'd0, 1);
      send(32'd100, 22'd50, 1'b1);
      expect_res("R6", C_ADV, 32'd430, 22'd280, 0);
   endtask

   task automatic t_wrap_back_to_back();
      @(negedge clk);
      drive(32'hFFFF_FFF0, 22'h20, 1'b0);
      @(negedge clk);
      drive(32'h0000_0010, 22'h8, 1'b0);
      expect_res("R12", C_NEW, 32'hFFFF_FFF0, 22'h20, 1);
      @(negedge clk);
      seg_valid = 1'b0;
      expect_res("R9", C_JPREV, 32'hFFFF_FFF0, 22'h28, 1);
      send(32'hFFFF_FF00, 22'hF0, 1'b1);
      expect_res("R9", C_ADV, 32'h0000_0018, 22'h28, 0);
      @(negedge clk);
      check("R12", "res_valid idle", res_valid, 0);
   endtask

   task automatic t_full_drain();
      logic [SEQ_W-1:0] base = 32'h1000_0000;
      for (int i = 0; i < DEPTH; i++) begin
         send(base + SEQ_W'(i * 256), 22'h10, 1'b0);
         check("R2", "fill code", res_code, C_NEW);
      end
      check("R8", "held at full", held, DEPTH);
      check("R8", "full", full, 1);
      send(32'h2000_0000, 22'h4, 1'b0);
      expect_res("R8", C_DROP, 32'h2000_0000, 22'h4, DEPTH);
      send(base + 32'h10, 22'h10, 1'b0);
      expect_res("R8", C_JPREV, base, 22'h20, DEPTH);
      send(32'h3000_0000, 22'h8, 1'b1);
      expect_res("R7", C_PASS, 32'h3000_0008, 22'h0, DEPTH);
      send(base - 32'h100, 22'h100, 1'b1);
      expect_res("R6", C_ADV, base + 32'h20, 22'h20, DEPTH - 1);
      check("R8", "full cleared", full, 0);
      for (int i = 1; i < DEPTH; i++) begin
         send(base + SEQ_W'(i * 256) - 32'h10, 22'h10, 1'b1);
         expect_res("R6", C_ADV, base + SEQ_W'(i * 256) + 32'h10, 22'h10, DEPTH - 1 - i);
      end
      check("R8", "full after drain", full, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n       = 1'b0;
      seg_valid   = 1'b0;
      seg_seq     = '0;
      seg_len     = '0;
      seg_inorder = 1'b0;
      repeat (3) @(negedge clk);
      check("R12", "reset held", held, 0);
      check("R12", "reset full", full, 0);
      check("R12", "reset res_valid", res_valid, 0);
      rst_n = 1'b1;
      t_inorder_idle();
      t_joins();
      t_zero_len();
      t_bridge_and_advance();
      t_wrap_back_to_back();
      t_full_drain();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule